// File: doc/BRIEF.md
# Ring-Cascaded FIFO Token Controller

This block builds one deep first-in first-out buffer out of several identical segments placed on a ring. Each segment owns a small memory and its own read and write pointers. A write token and a read token circulate around the ring. Only the segment holding the write token stores the shared input word, and only the segment holding the read token supplies the shared output register. A segment hands a token to its neighbour when an access lands in its last physical slot, so words stay in strict arrival order across segment boundaries, including the wrap from the last segment back to the first.

Each segment has an active-low first-load input. At reset the segment whose first-load input is low takes both tokens, and every other segment takes neither. Write and read share one clock. The handoff pulses of each segment feed the expansion input of the next segment, and the last segment feeds the first. They are also brought out as ports. The buffer-level empty, full, almost-empty and almost-full flags are each the AND of the matching per-segment flags. The two almost flags are therefore coarse indications. In this arrangement there is no half-full output.

Top module: `cascade_fifo`

## Requirements
- R1: During reset the segment whose `first_load_n` bit is 0 takes both tokens and all others take none. After reset `empty`=1, `full`=0, and the output register holds 0.
- R2: A word is stored only when `wr_en`=1 and `full`=0. It goes into the write-token segment at that segment's write pointer, and reads return the words in write order.
- R3: A write into the last slot of the write-token segment i raises bit i of `wr_hand` in that same cycle, for that cycle only. After that clock edge, bit (i+1) mod NSEG of `wr_token` holds the token. Exactly one bit of `wr_token` is set at all times.
- R4: A read from the last slot of the read-token segment i raises bit i of `rd_hand` in that same cycle. After that clock edge, bit (i+1) mod NSEG of `rd_token` is set. Exactly one bit of `rd_token` is set at all times.
- R5: A read with `rd_en`=1 and `empty`=0 loads the oldest word, taken from the read-token segment, into the output register at that edge. `dout` shows the register when `oe`=1 and shows 0 when `oe`=0.
- R6: A write attempted while `full`=1 changes nothing. No token moves, no handoff pulse appears, and no extra word is read back later.
- R7: A read attempted while `empty`=1 changes nothing, and the output register keeps the last word read.
- R8: `empty` is 1 exactly when every segment holds zero words. `full` is 1 exactly when every segment holds SEG_DEPTH words.
- R9: `almost_empty` is 1 when every segment holds at most AE_OFS words. `almost_full` is 1 when every segment holds at least SEG_DEPTH-AF_OFS words.
- R10: A read and a write in the same cycle both take effect, including the cycle in which the read handoff and the write handoff happen together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared read/write clock |
| rst_n | input | 1 | Synchronous active-low reset |
| first_load_n | input | NSEG | Active-low start marker, one bit per segment |
| wr_en | input | 1 | Write request |
| din | input | WIDTH | Write data shared by all segments |
| rd_en | input | 1 | Read request |
| oe | input | 1 | Output enable for `dout` |
| dout | output | WIDTH | Output register, or 0 when disabled |
| empty | output | 1 | Composite empty |
| full | output | 1 | Composite full |
| almost_empty | output | 1 | Composite almost-empty |
| almost_full | output | 1 | Composite almost-full |
| wr_token | output | NSEG | Write token holder, one-hot |
| rd_token | output | NSEG | Read token holder, one-hot |
| wr_hand | output | NSEG | Write handoff pulses, segment i to i+1 |
| rd_hand | output | NSEG | Read handoff pulses, segment i to i+1 |

## Verification
The case most likely to break is a read handoff and a write handoff in the same cycle. In that cycle both tokens leave their segments at the same edge while words are also entering and leaving. The bench provokes it by filling exactly one segment's worth of words, or a multiple of it, and then asserting read and write together on every cycle, so that both pointers reach a last slot together. It repeats this for several fill levels and for every choice of starting segment. An arithmetic model of ring positions judges every cycle: it predicts both pulse vectors before the edge, and after the edge it predicts the tokens, the flags and the returned word.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
    typedef struct packed {
        logic empty;
        logic full;
        logic almost_empty;
        logic almost_full;
    } seg_flags_t;
endpackage

// File: rtl/cfifo_seg.sv
module cfifo_seg
    import cfifo_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 4,
    parameter int AE_OFS = 1,
    parameter int AF_OFS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_n,
    input  logic             wxi,
    input  logic             rxi,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] din,
    output logic             wxo,
    output logic             rxo,
    output logic             wtok,
    output logic             rtok,
    output logic             rd_fire,
    output logic [WIDTH-1:0] rd_data,
    output seg_flags_t       flags
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          wtok;
        logic          rtok;
    } seg_state_t;

    seg_state_t s_d, s_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic wr_fire;

    always_comb begin
        flags.empty        = (s_q.cnt == '0);
        flags.full         = (s_q.cnt == CW'(DEPTH));
        flags.almost_empty = (s_q.cnt <= CW'(AE_OFS));
        flags.almost_full  = (s_q.cnt >= CW'(DEPTH - AF_OFS));

        wr_fire = wr_en && s_q.wtok && !flags.full;
        rd_fire = rd_en && s_q.rtok && !flags.empty;
        wxo     = wr_fire && (s_q.wptr == LAST);
        rxo     = rd_fire && (s_q.rptr == LAST);

        s_d = s_q;
        if (wr_fire) s_d.wptr = (s_q.wptr == LAST) ? '0 : s_q.wptr + AW'(1);
        if (rd_fire) s_d.rptr = (s_q.rptr == LAST) ? '0 : s_q.rptr + AW'(1);
        if (wr_fire && !rd_fire) s_d.cnt = s_q.cnt + CW'(1);
        if (rd_fire && !wr_fire) s_d.cnt = s_q.cnt - CW'(1);
        // hand off first, then take: a one-segment ring keeps its token
        if (wxo) s_d.wtok = 1'b0;
        if (wxi) s_d.wtok = 1'b1;
        if (rxo) s_d.rtok = 1'b0;
        if (rxi) s_d.rtok = 1'b1;

        if (!rst_n) begin
            s_d      = '0;
            s_d.wtok = !first_n;
            s_d.rtok = !first_n;
        end
    end

    always_ff @(posedge clk) s_q <= s_d;

    always_ff @(posedge clk) begin
        if (wr_fire) mem[s_q.wptr] <= din;
    end

    assign rd_data = mem[s_q.rptr];
    assign wtok    = s_q.wtok;
    assign rtok    = s_q.rtok;
endmodule

// File: rtl/cfifo_flag_merge.sv
module cfifo_flag_merge
    import cfifo_pkg::*;
#(
    parameter int NSEG = 3
) (
    input  seg_flags_t [NSEG-1:0] seg_flags,
    output seg_flags_t            merged
);
    always_comb begin
        merged = '1;
        for (int i = 0; i < NSEG; i++) begin
            merged.empty        = merged.empty        & seg_flags[i].empty;
            merged.full         = merged.full         & seg_flags[i].full;
            merged.almost_empty = merged.almost_empty & seg_flags[i].almost_empty;
            merged.almost_full  = merged.almost_full  & seg_flags[i].almost_full;
        end
    end
endmodule

// File: rtl/cascade_fifo.sv
module cascade_fifo
    import cfifo_pkg::*;
#(
    parameter int NSEG     = 3,
    parameter int WIDTH    = 8,
    parameter int SEG_DEPTH = 4,
    parameter int AE_OFS   = 1,
    parameter int AF_OFS   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSEG-1:0] first_load_n,
    input  logic            wr_en,
    input  logic [WIDTH-1:0] din,
    input  logic            rd_en,
    input  logic            oe,
    output logic [WIDTH-1:0] dout,
    output logic            empty,
    output logic            full,
    output logic            almost_empty,
    output logic            almost_full,
    output logic [NSEG-1:0] wr_token,
    output logic [NSEG-1:0] rd_token,
    output logic [NSEG-1:0] wr_hand,
    output logic [NSEG-1:0] rd_hand
);
    typedef struct packed {
        logic [WIDTH-1:0] dq;
    } top_state_t;

    top_state_t t_d, t_q;
    seg_flags_t [NSEG-1:0] seg_flags;
    seg_flags_t            all_flags;
    logic [NSEG-1:0]       wxi, rxi, rd_fire;
    logic [WIDTH-1:0]      seg_data [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        localparam int PREV = (i + NSEG - 1) % NSEG;
        assign wxi[i] = wr_hand[PREV];
        assign rxi[i] = rd_hand[PREV];

        cfifo_seg #(
            .WIDTH (WIDTH),
            .DEPTH (SEG_DEPTH),
            .AE_OFS(AE_OFS),
            .AF_OFS(AF_OFS)
        ) u_seg (
            .clk    (clk),
            .rst_n  (rst_n),
            .first_n(first_load_n[i]),
            .wxi    (wxi[i]),
            .rxi    (rxi[i]),
            .wr_en  (wr_en),
            .rd_en  (rd_en),
            .din    (din),
            .wxo    (wr_hand[i]),
            .rxo    (rd_hand[i]),
            .wtok   (wr_token[i]),
            .rtok   (rd_token[i]),
            .rd_fire(rd_fire[i]),
            .rd_data(seg_data[i]),
            .flags  (seg_flags[i])
        );
    end

    cfifo_flag_merge #(.NSEG(NSEG)) u_merge (
        .seg_flags(seg_flags),
        .merged   (all_flags)
    );

    always_comb begin
        t_d = t_q;
        for (int i = 0; i < NSEG; i++) begin
            if (rd_fire[i]) t_d.dq = seg_data[i];
        end
        if (!rst_n) t_d = '0;
    end

    always_ff @(posedge clk) t_q <= t_d;

    assign dout         = oe ? t_q.dq : '0;
    assign empty        = all_flags.empty;
    assign full         = all_flags.full;
    assign almost_empty = all_flags.almost_empty;
    assign almost_full  = all_flags.almost_full;
endmodule

// File: rtl/cascade_fifo_chk.sv
module cascade_fifo_chk #(
    parameter int NSEG = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic            empty,
    input logic            full,
    input logic [NSEG-1:0] wr_token,
    input logic [NSEG-1:0] rd_token,
    input logic [NSEG-1:0] wr_hand,
    input logic [NSEG-1:0] rd_hand
);
    AST_WTOK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $countones(wr_token) == 1); // R3
    AST_RTOK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $countones(rd_token) == 1); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (wr_hand != '0) |-> (wr_en && !full)); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (rd_hand != '0) |-> (rd_en && !empty)); // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(empty && full)); // R8
    AST_WHAND_SRC: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_hand) && ((wr_hand & ~wr_token) == '0)); // R3
    AST_RHAND_SRC: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rd_hand) && ((rd_hand & ~rd_token) == '0)); // R4

    for (genvar i = 0; i < NSEG; i++) begin : g_ring
        localparam int NXT = (i + 1) % NSEG;
        AST_WTOK_MOVE: assert property (@(posedge clk) disable iff (!rst_n) wr_hand[i] |=> wr_token[NXT]); // R3
        AST_RTOK_MOVE: assert property (@(posedge clk) disable iff (!rst_n) rd_hand[i] |=> rd_token[NXT]); // R4
    end
endmodule

bind cascade_fifo cascade_fifo_chk #(.NSEG(NSEG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .empty   (empty),
    .full    (full),
    .wr_token(wr_token),
    .rd_token(rd_token),
    .wr_hand (wr_hand),
    .rd_hand (rd_hand)
);

// File: tb/sim_cascade_fifo.sv
`timescale 1ns/1ps
module sim_cascade_fifo;
    localparam int N = 3, W = 8, D = 4, AE = 1, AF = 1, TOT = N * D;

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, oe = 0;
    logic [N-1:0] first_load_n = '1;
    logic [W-1:0] din = '0, dout;
    logic empty, full, almost_empty, almost_full;
    logic [N-1:0] wr_token, rd_token, wr_hand, rd_hand;

    always #4 clk = ~clk;

    cascade_fifo #(.NSEG(N), .WIDTH(W), .SEG_DEPTH(D), .AE_OFS(AE), .AF_OFS(AF)) u0 (
        .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n), .wr_en(wr_en), .din(din),
        .rd_en(rd_en), .oe(oe), .dout(dout), .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full), .wr_token(wr_token),
        .rd_token(rd_token), .wr_hand(wr_hand), .rd_hand(rd_hand));

    int checks = 0, errors = 0;
    int first, wpos, rpos, cnt;
    logic [W-1:0] slot [TOT];
    logic         vld  [TOT];
    logic [W-1:0] last_word, seq;
    logic [15:0]  lf = 16'hACE1;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int segof(input int p);
        return (first + p / D) % N;
    endfunction

    task automatic check_state(input logic oe_v);
        int sc [N];
        logic ae_e, af_e;
        for (int i = 0; i < N; i++) sc[i] = 0;
        for (int p = 0; p < TOT; p++) if (vld[p]) sc[segof(p)]++;
        ae_e = 1; af_e = 1;
        for (int i = 0; i < N; i++) begin
            if (sc[i] > AE) ae_e = 0;
            if (sc[i] < D - AF) af_e = 0;
        end
        chk("R3 wr_token", 32'(wr_token), 32'(1 << segof(wpos)));
        chk("R4 rd_token", 32'(rd_token), 32'(1 << segof(rpos)));
        chk("R8 empty", 32'(empty), 32'(cnt == 0));
        chk("R8 full", 32'(full), 32'(cnt == TOT));
        chk("R9 almost_empty", 32'(almost_empty), 32'(ae_e));
        chk("R9 almost_full", 32'(almost_full), 32'(af_e));
        chk("R5 R7 dout", 32'(dout), oe_v ? 32'(last_word) : 32'd0);
    endtask

    task automatic step(input logic we, input logic re, input logic oe_v);
        logic wacc, racc;
        logic [N-1:0] wh, rh;
        @(negedge clk);
        wr_en = we; rd_en = re; oe = oe_v; din = seq;
        #1;
        wacc = we && (cnt < TOT);
        racc = re && (cnt > 0);
        wh = (wacc && (wpos % D == D - 1)) ? N'(1 << segof(wpos)) : '0;
        rh = (racc && (rpos % D == D - 1)) ? N'(1 << segof(rpos)) : '0;
        chk("R3 R6 wr_hand", 32'(wr_hand), 32'(wh));
        chk("R4 R10 rd_hand", 32'(rd_hand), 32'(rh));
        @(posedge clk); #1;
        if (racc) begin
            last_word = slot[rpos]; vld[rpos] = 0;
            rpos = (rpos + 1) % TOT; cnt--;
        end
        if (wacc) begin
            slot[wpos] = seq; vld[wpos] = 1;
            wpos = (wpos + 1) % TOT; cnt++; seq++;
        end
        check_state(oe_v);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic do_reset(input int f);
        first = f;
        @(negedge clk);
        rst_n = 0; wr_en = 0; rd_en = 0; oe = 1;
        first_load_n = ~(N'(1) << f);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        wpos = 0; rpos = 0; cnt = 0; last_word = '0;
        for (int p = 0; p < TOT; p++) vld[p] = 0;
        chk("R1 wr_token", 32'(wr_token), 32'(1 << f));
        chk("R1 rd_token", 32'(rd_token), 32'(1 << f));
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 dout", 32'(dout), 32'd0);
    endtask

    initial begin
        seq = 8'h10;
        for (int f = 0; f < N; f++) begin
            do_reset(f);
            // R2 R6: fill past capacity across every write handoff
            for (int k = 0; k < TOT + 2; k++) step(1, 0, 1);
            // R5 R7: drain past empty with output enable toggling
            for (int k = 0; k < TOT + 2; k++) step(0, 1, k[0]);
            // R10: coinciding read and write, several fill offsets
            for (int fill = 0; fill <= D + 2; fill++) begin
                while (cnt > 0) step(0, 1, 1);
                for (int k = 0; k < fill; k++) step(1, 0, 1);
                for (int k = 0; k < 2 * TOT + 3; k++) step(1, 1, 1);
            end
            // R2 mixed traffic
            for (int k = 0; k < 300; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0], lf[1] | lf[2], lf[3] | lf[4]);
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule